// File: doc/BRIEF.md
# Glitchless Two-Source Clock Selector with Fan-Out

This block chooses one of two unrelated input clocks and distributes it to a bank of identical complementary output pairs. When the selection changes, it never produces a shortened pulse. The outgoing clock is first stopped low, on one of its own falling edges. The incoming clock is then admitted, on one of its own rising edges. The two clocks stay out of step because of a handshake. Each clock domain owns a short enable synchronizer that runs on that clock's falling edge. A domain raises its enable only after it has seen the other domain's enable drop.

A force input covers the case where one source has stopped. Its rising edge blanks the output at once, with no help from the stalled handshake. The output then restarts on the clock that the select input names. While force stays high, the deselected clock cannot reach the output, whether it is running or not.

Two overrides sit above the clock path and do not depend on any clock. The first is a gate input, which parks every pair at a chosen polarity. The second is an active-low power-down input, which drives both wires of every pair high. Power-down has the higher priority of the two.

Top module: `clksw_top`

## Requirements
- R1: With `sel` high the outputs follow `clk_a`, and with `sel` low they follow `clk_b`, once any switch has completed.
- R2: After `sel` changes, the last high pulse of the outgoing clock ends on one of its own falling edges, no later than three periods of that clock after the change.
- R3: The low interval during a switch lasts at most three periods of the incoming clock. The output resumes on a rising edge of the incoming clock. No high pulse during a switch is shorter than half a period of the faster clock.
- R4: A rising edge on `force_sel` drives every true output low and every complement output high in the same time step, with no clock edge needed. The outputs then restart on the clock named by `sel`.
- R5: While `force_sel` is held high, the deselected clock has no effect on the outputs, whether it is stopped high or running.
- R6: With `gate` high and `pwr_n` high, every pair is parked at once at the level set by `park_lvl`. With `gate` low, the pairs follow the selected clock.
- R7: A parked pair drives true=1 and complement=0 when `park_lvl` is 1, and true=0 and complement=1 when `park_lvl` is 0.
- R8: With `pwr_n` low, every true and every complement output is 1, whatever `gate`, `park_lvl` and the clocks are doing.
- R9: During `rst`, the enable of `clk_a` is loaded from `sel` and the enable of `clk_b` is loaded from its inverse. Right after reset, the outputs follow the selected clock with no handshake.
- R10: All pairs carry the same value. While `pwr_n` is high, each complement output is the exact inverse of its true output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Input clock picked when `sel` is 1 |
| clk_b | input | 1 | Input clock picked when `sel` is 0 |
| rst | input | 1 | Synchronous active-high reset, sampled on each clock's falling edge |
| sel | input | 1 | Source choice: 1 = `clk_a`, 0 = `clk_b` |
| force_sel | input | 1 | Rising edge bypasses the handshake; held high to isolate the other source |
| gate | input | 1 | 1 parks all pairs asynchronously |
| park_lvl | input | 1 | Level of the true wire when parked |
| pwr_n | input | 1 | Active-low power-down; 0 drives both wires of every pair high |
| q_t | output | N_OUT (6) | True wire of each output pair |
| q_c | output | N_OUT (6) | Complement wire of each output pair |

## Verification
The force rising edge can land in the same cycle as a handshake that is stalled halfway. The bench provokes this by stopping `clk_b` while it is high and selected, then flipping `sel`, so the old enable can never drop. The output stays stuck high until `force_sel` rises. The outputs are then judged to go low in that same time step and to settle on `clk_a`, matched sample by sample against the bench's model. They must stay on `clk_a` after the stopped clock runs again and after force is released. A second overlap is power-down arriving while the gate already parks the pairs; there the model demands all-high outputs whatever the park level.

// File: rtl/clksw_pkg.sv
`timescale 1ns/1ps
package clksw_pkg;

    // Depth of every falling-edge synchronizer chain.
    localparam int unsigned SYNC_DEPTH = 2;

    // How an output pair is being driven.
    typedef enum logic [1:0] {
        DRV_CLOCK = 2'd0,
        DRV_PARK  = 2'd1,
        DRV_SLEEP = 2'd2
    } drv_mode_e;

    typedef struct packed {
        logic tru;
        logic cmp;
    } pair_t;

    // Synchronized view a clock domain exposes to the rest of the block.
    typedef struct packed {
        logic en;   // this clock may reach the output
        logic fs;   // force request has been seen in this domain
    } dom_state_t;

    // Power-down outranks the gate.
    function automatic drv_mode_e pick_mode(logic pwr_n, logic gate);
        drv_mode_e m;
        if (!pwr_n)    m = DRV_SLEEP;
        else if (gate) m = DRV_PARK;
        else           m = DRV_CLOCK;
        return m;
    endfunction

    function automatic pair_t drive_pair(drv_mode_e m, logic ck, logic lvl);
        pair_t p;
        unique case (m)
            DRV_SLEEP: begin p.tru = 1'b1; p.cmp = 1'b1; end
            DRV_PARK:  begin p.tru = lvl;  p.cmp = ~lvl; end
            default:   begin p.tru = ck;   p.cmp = ~ck;  end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/clksw_domain.sv
`timescale 1ns/1ps
module clksw_domain
    import clksw_pkg::*;
#(
    parameter int unsigned STAGES = SYNC_DEPTH
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pick_me,
    input  logic       peer_en,
    input  logic       force_in,
    output dom_state_t st
);

    logic [STAGES-1:0] en_sr;
    logic [STAGES-1:0] fs_sr;
    logic              req;

    // Once force is seen here, the peer enable is ignored.
    always_comb begin
        if (fs_sr[STAGES-1]) req = pick_me;
        else                 req = pick_me & ~peer_en;
    end

    always_ff @(negedge clk) begin
        if (rst) begin
            en_sr <= {STAGES{pick_me}};
            fs_sr <= '0;
        end else begin
            en_sr <= {en_sr[STAGES-2:0], req};
            fs_sr <= {fs_sr[STAGES-2:0], force_in};
        end
    end

    assign st.en = en_sr[STAGES-1];
    assign st.fs = fs_sr[STAGES-1];

endmodule

// File: rtl/clksw_pair.sv
`timescale 1ns/1ps
module clksw_pair
    import clksw_pkg::*;
(
    input  drv_mode_e mode,
    input  logic      ck,
    input  logic      lvl,
    output logic      q_t,
    output logic      q_c
);

    pair_t p;

    always_comb p = drive_pair(mode, ck, lvl);

    assign q_t = p.tru;
    assign q_c = p.cmp;

endmodule

// File: rtl/clksw_top.sv
`timescale 1ns/1ps
module clksw_top
    import clksw_pkg::*;
#(
    parameter int unsigned N_OUT       = 6,
    parameter int unsigned SYNC_STAGES = SYNC_DEPTH
) (
    input  logic             clk_a,
    input  logic             clk_b,
    input  logic             rst,
    input  logic             sel,
    input  logic             force_sel,
    input  logic             gate,
    input  logic             park_lvl,
    input  logic             pwr_n,
    output logic [N_OUT-1:0] q_t,
    output logic [N_OUT-1:0] q_c
);

    dom_state_t st_a;
    dom_state_t st_b;
    logic       sel_n;
    logic       dom_a_en, dom_b_en;
    logic       dom_a_fs, dom_b_fs;
    logic       blank_a, blank_b;
    logic       gclk;
    drv_mode_e  mode;

    assign sel_n = ~sel;

    clksw_domain #(.STAGES(SYNC_STAGES)) u_dom_a (
        .clk      (clk_a),
        .rst      (rst),
        .pick_me  (sel),
        .peer_en  (dom_b_en),
        .force_in (force_sel),
        .st       (st_a)
    );

    clksw_domain #(.STAGES(SYNC_STAGES)) u_dom_b (
        .clk      (clk_b),
        .rst      (rst),
        .pick_me  (sel_n),
        .peer_en  (dom_a_en),
        .force_in (force_sel),
        .st       (st_b)
    );

    assign dom_a_en = st_a.en;
    assign dom_b_en = st_b.en;
    assign dom_a_fs = st_a.fs;
    assign dom_b_fs = st_b.fs;

    // A fresh force request masks a domain until that domain has seen it.
    assign blank_a = force_sel & ~dom_a_fs;
    assign blank_b = force_sel & ~dom_b_fs;

    assign gclk = (clk_a & dom_a_en & ~blank_a) | (clk_b & dom_b_en & ~blank_b);

    always_comb mode = pick_mode(pwr_n, gate);

    for (genvar i = 0; i < N_OUT; i++) begin : g_pair
        clksw_pair u_pair (
            .mode (mode),
            .ck   (gclk),
            .lvl  (park_lvl),
            .q_t  (q_t[i]),
            .q_c  (q_c[i])
        );
    end

endmodule

// File: rtl/clksw_chk.sv
`timescale 1ns/1ps
module clksw_chk #(
    parameter int unsigned N_OUT = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             force_sel,
    input logic             gate,
    input logic             park_lvl,
    input logic             pwr_n,
    input logic             en_a,
    input logic             en_b,
    input logic             fs_a,
    input logic             fs_b,
    input logic [N_OUT-1:0] q_t,
    input logic [N_OUT-1:0] q_c
);

    p_park_level_r6: assert property (@(posedge clk) disable iff (rst)
        (gate && pwr_n) |-> (q_t == {N_OUT{park_lvl}}));

    p_park_cmp_r7: assert property (@(posedge clk) disable iff (rst)
        (gate && pwr_n) |-> (q_c == {N_OUT{~park_lvl}}));

    p_sleep_high_r8: assert property (@(posedge clk) disable iff (rst)
        !pwr_n |-> ((&q_t) && (&q_c)));

    p_pair_match_r10: assert property (@(posedge clk) disable iff (rst)
        pwr_n |-> ((q_c == ~q_t) && (q_t == {N_OUT{q_t[0]}})));

    p_enable_excl_r3: assert property (@(posedge clk) disable iff (rst)
        (!force_sel && !fs_a && !fs_b) |-> !(en_a && en_b));

endmodule

bind clksw_top clksw_chk #(.N_OUT(N_OUT)) u_chk (
    .clk       (clk_a),
    .rst       (rst),
    .force_sel (force_sel),
    .gate      (gate),
    .park_lvl  (park_lvl),
    .pwr_n     (pwr_n),
    .en_a      (dom_a_en),
    .en_b      (dom_b_en),
    .fs_a      (dom_a_fs),
    .fs_b      (dom_b_fs),
    .q_t       (q_t),
    .q_c       (q_c)
);

// File: tb/clksw_top_tb.sv
`timescale 1ns/1ps
module clksw_top_tb;

    localparam int  N  = 6;
    localparam real TA = 20.0;
    localparam real TB = 34.0;

    logic clk_a = 1'b0;
    logic clk_b = 1'b0;
    logic b_run = 1'b1;
    logic rst = 1'b1, sel = 1'b1, force_sel = 1'b0;
    logic gate = 1'b0, park_lvl = 1'b0, pwr_n = 1'b1;
    logic [N-1:0] q_t, q_c;

    int    vectors = 0;
    int    miscompares = 0;
    int    exp_src = 0;        // 0: no clock expectation, 1: clk_a, 2: clk_b
    string tag = "R9";

    real last_fall = 0.0, last_rise = 0.0, worst_gap = 0.0, gap_fall = 0.0;
    bit  meas = 1'b0;
    int  runts = 0;

    clksw_top #(.N_OUT(N)) u_dut (
        .clk_a(clk_a), .clk_b(clk_b), .rst(rst), .sel(sel),
        .force_sel(force_sel), .gate(gate), .park_lvl(park_lvl),
        .pwr_n(pwr_n), .q_t(q_t), .q_c(q_c)
    );

    always #10 clk_a = ~clk_a;
    always begin
        #17;
        if (b_run) clk_b = ~clk_b;
    end

    task automatic compare(string t, logic [N-1:0] et, logic [N-1:0] ec);
        vectors++;
        if (q_t !== et || q_c !== ec) begin
            miscompares++;
            $display("FAIL %s: q_t=%b q_c=%b expected q_t=%b q_c=%b at %0t",
                     t, q_t, q_c, et, ec, $time);
        end
    endtask

    task automatic model_check(logic ck);
        logic [N-1:0] et, ec;
        if (!pwr_n)    begin et = '1; ec = '1; end
        else if (gate) begin et = {N{park_lvl}}; ec = ~et; end
        else           begin et = {N{ck}}; ec = ~et; end
        compare(tag, et, ec);
    endtask

    task automatic check_pairs();
        vectors++;
        if (q_c !== ~q_t || q_t !== {N{q_t[0]}}) begin
            miscompares++;
            $display("FAIL R10: q_t=%b q_c=%b expected equal pairs with inverted complements",
                     q_t, q_c);
        end
    endtask

    // Behavioural reference, compared on both edges of the tracked clock.
    always @(clk_a) begin
        #3;
        if (!pwr_n || gate || exp_src == 1) model_check(clk_a);
    end
    always @(clk_b) begin
        #3;
        if (pwr_n && !gate && exp_src == 2) model_check(clk_b);
    end

    // Pulse and gap measurement on one output wire.
    always @(posedge q_t[0]) begin
        if (meas && ($realtime - last_fall) > worst_gap) begin
            worst_gap = $realtime - last_fall;
            gap_fall  = last_fall;
        end
        last_rise = $realtime;
    end
    always @(negedge q_t[0]) begin
        if (meas && ($realtime - last_rise) < 9.0) runts++;
        last_fall = $realtime;
    end

    task automatic switch_to(logic new_sel);
        real t0, t_old, t_new;
        t_old = new_sel ? TB : TA;
        t_new = new_sel ? TA : TB;
        exp_src = 0;
        worst_gap = 0.0;
        runts = 0;
        t0 = $realtime;
        meas = 1'b1;
        sel = new_sel;
        #(4.0 * (t_old + t_new));
        meas = 1'b0;
        vectors++;
        if (gap_fall - t0 > 3.0 * t_old) begin
            miscompares++;
            $display("FAIL R2: old clock stopped %0.1f ns after select, expected <= %0.1f",
                     gap_fall - t0, 3.0 * t_old);
        end
        vectors++;
        if (worst_gap > 3.0 * t_new) begin
            miscompares++;
            $display("FAIL R3: low gap %0.1f ns, expected <= %0.1f", worst_gap, 3.0 * t_new);
        end
        vectors++;
        if (runts != 0) begin
            miscompares++;
            $display("FAIL R3: %0d short pulses, expected 0", runts);
        end
        tag = "R1";
        exp_src = new_sel ? 1 : 2;
        #(6.0 * t_new);
        check_pairs();
    endtask

    initial begin
        #100000;
        miscompares++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        // R9: reset with sel high, clk_a owns the output right away.
        #200;
        rst = 1'b0;
        tag = "R9";
        exp_src = 1;
        #200;
        check_pairs();

        // R1/R2/R3: handshake both ways.
        switch_to(1'b0);
        switch_to(1'b1);

        // R6/R7/R8 on the asynchronous overrides.
        @(posedge clk_a); #4;
        gate = 1'b1; park_lvl = 1'b1;
        #1 compare("R6", '1, '0);
        tag = "R6"; #100;
        park_lvl = 1'b0;
        #1 compare("R7", '0, '1);
        tag = "R7"; #100;
        pwr_n = 1'b0;
        #1 compare("R8", '1, '1);
        gate = 1'b0;
        #1 compare("R8", '1, '1);
        park_lvl = 1'b1;
        tag = "R8"; #100;
        pwr_n = 1'b1;
        #1 compare("R6", {N{clk_a}}, ~{N{clk_a}});
        tag = "R6"; #100;
        check_pairs();

        // R4: force while clk_a is high and selected.
        @(posedge clk_a); #4;
        exp_src = 0;
        force_sel = 1'b1;
        #1 compare("R4", '0, '1);
        #(4.0 * TA);
        tag = "R4"; exp_src = 1;
        #(6.0 * TA);
        force_sel = 1'b0;
        #(6.0 * TA);

        // R4/R5: selected clk_b stops high, handshake stalls, force rescues.
        switch_to(1'b0);
        exp_src = 0;
        @(posedge clk_b); #2;
        b_run = 1'b0;
        #50;
        sel = 1'b1;
        #100;
        force_sel = 1'b1;
        #1 compare("R4", '0, '1);
        #150;
        tag = "R5"; exp_src = 1;
        #200;
        b_run = 1'b1;
        #300;
        force_sel = 1'b0;
        #200;
        check_pairs();

        // Normal handshake after release.
        switch_to(1'b0);
        switch_to(1'b1);

        // R9: reset with sel low skips the handshake.
        exp_src = 0;
        rst = 1'b1;
        #5 sel = 1'b0;
        #200;
        rst = 1'b0;
        tag = "R9"; exp_src = 2;
        #300;
        check_pairs();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule